// File: doc/BRIEF.md
# Ordered Store Buffer with Drain Events

This block sits between a processor's store and load ports and one shared memory port. Ordinary stores are kept in a small queue and written to memory one at a time, oldest first. The queue retires an entry whenever the memory port has nothing more urgent to do. A load that arrives while stores are still queued searches the queue, so software sees the same values it would see with no queue present. A load that needs memory is given the port ahead of any queued store.

Some events need every earlier store to be finished before they can go ahead. These are fences, serializing events, I/O and locked accesses, and interrupts and exceptions. The event input blocks new ordinary stores and holds its acknowledge low until the queue is empty. Writes marked as bypassing (I/O space or locked) are never queued. Each one waits for an empty queue and then goes to memory directly. An uncacheable load also waits for an empty queue before it reads memory.

Top module: `ord_store_buf`

## Requirements
- R1: After reset the queue is empty (`sb_empty`=1), `mem_valid`, `ld_done` and `drain_done` are 0, and an idle store port shows `st_ready`=1.
- R2: Queued stores reach the memory port as writes (`mem_we`=1) strictly in the order they were accepted, each with its own address, data and byte enables.
- R3: The queue holds DEPTH (default 8) stores. An ordinary store offered while it is full sees `st_ready`=0 and is not taken.
- R4: A cacheable load whose youngest matching queued entry has the same full address and all byte enables set completes in the same cycle (`ld_done`=1) with that entry's data and uses no memory read.
- R5: A cacheable load whose youngest matching entry has only some byte enables set is held (`ld_done`=0) until that entry has been written. It then reads memory and returns the memory data.
- R6: When a load needs memory while stores are queued, the memory port carries the read (`mem_we`=0, load address) before any further queued write.
- R7: While `ev_req` is 1, no ordinary store is accepted. `ev_ack` rises only once the queue is empty.
- R8: A store with `st_bypass`=1 is accepted only when the queue is empty. It goes straight to memory as a write and is never queued, so `sb_empty` stays 1.
- R9: A load with `ld_uncached`=1 does not read memory until every queued store has been written. The queue is not searched for it.
- R10: `drain_done` pulses for one cycle in the cycle the memory port accepts the last queued entry, provided no store enters the queue in that cycle.
- R11: While a load is in progress (`ld_valid`=1 until its `ld_done` cycle), stores are not accepted, so a younger store can never feed an older load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store taken this cycle |
| st_bypass | input | 1 | Store is an I/O or locked write that must not be queued |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load request, held until ld_done |
| ld_uncached | input | 1 | Load is uncacheable |
| ld_addr | input | AW | Load word address |
| ld_done | output | 1 | Load result valid this cycle |
| ld_rdata | output | DW | Load result |
| ev_req | input | 1 | Drain event pending (fence, serialize, I/O, lock, interrupt) |
| ev_ack | output | 1 | Queue empty, event may proceed |
| sb_empty | output | 1 | Queue holds no stores |
| drain_done | output | 1 | Last queued entry accepted by memory |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables (all ones for reads) |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DW | Read data |

## Verification
Loads are driven against three queue contents: a younger full-word match over an older one at the same address, a partial-lane match, and no match. These show that the youngest entry is chosen, that partial coverage stalls instead of forwarding stale bytes, and that misses win the port over pending writes. The memory ready line is held low to build up a backlog and then released. The order of accepted operations then separates in-order retirement, read priority, and the drain waits that an uncacheable load, a bypass write and an event each need. A full queue and a store offered during a held load check the stall paths.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [1:0] {
    PORT_IDLE,
    PORT_LOAD,
    PORT_BYPASS,
    PORT_RETIRE
  } port_src_e;

  // advance a ring pointer by one slot
  function automatic int unsigned ring_step(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // slot holding the entry that is `age` places younger than the head
  function automatic int unsigned ring_age(int unsigned head, int unsigned age, int unsigned n);
    return (head + age) % n;
  endfunction

  // true when the low `lanes` bits of the enable vector are all set
  function automatic logic covers_word(logic [63:0] be, int unsigned lanes);
    for (int unsigned i = 0; i < lanes; i++) begin
      if (!be[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring import sbuf_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  push,
  input  logic [AW-1:0]                         push_addr,
  input  logic [DW-1:0]                         push_data,
  input  logic [DW/8-1:0]                       push_be,
  input  logic                                  pop,
  output logic [AW-1:0]                         ent_addr [DEPTH],
  output logic [DW-1:0]                         ent_data [DEPTH],
  output logic [DW/8-1:0]                       ent_be   [DEPTH],
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] head_ptr,
  output logic [$clog2(DEPTH+1)-1:0]            occ
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] tail_ptr;

  // storage carries no reset: only slots below occ are ever looked at
  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_ptr] <= push_addr;
      ent_data[tail_ptr] <= push_data;
      ent_be[tail_ptr]   <= push_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      occ      <= '0;
    end else begin
      if (push) tail_ptr <= PW'(ring_step(32'(tail_ptr), DEPTH));
      if (pop)  head_ptr <= PW'(ring_step(32'(head_ptr), DEPTH));
      unique case ({push, pop})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ != '0)); // R2
  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH) && !pop) |-> !push); // R3

endmodule

// File: rtl/sbuf_match.sv
module sbuf_match import sbuf_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic [AW-1:0]                         ent_addr [DEPTH],
  input  logic [DW-1:0]                         ent_data [DEPTH],
  input  logic [DW/8-1:0]                       ent_be   [DEPTH],
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] head_ptr,
  input  logic [$clog2(DEPTH+1)-1:0]            occ,
  input  logic [AW-1:0]                         probe_addr,
  output logic                                  hit,
  output logic                                  hit_whole,
  output logic [DW-1:0]                         hit_data
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BEW = DW / 8;

  // walk oldest to youngest; the last match seen is the youngest one
  always_comb begin : scan
    logic [PW-1:0] slot;
    slot      = '0;
    hit       = 1'b0;
    hit_whole = 1'b0;
    hit_data  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = PW'(ring_age(32'(head_ptr), i, DEPTH));
      if (32'(i) < 32'(occ) && ent_addr[slot] == probe_addr) begin
        hit       = 1'b1;
        hit_whole = covers_word(64'(ent_be[slot]), BEW);
        hit_data  = ent_data[slot];
      end
    end
  end

endmodule

// File: rtl/sbuf_port_arb.sv
module sbuf_port_arb import sbuf_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_req,
  input  logic [AW-1:0]   ld_addr,
  input  logic            byp_req,
  input  logic [AW-1:0]   byp_addr,
  input  logic [DW-1:0]   byp_data,
  input  logic [DW/8-1:0] byp_be,
  input  logic            buf_req,
  input  logic [AW-1:0]   buf_addr,
  input  logic [DW-1:0]   buf_data,
  input  logic [DW/8-1:0] buf_be,
  input  logic            mem_ready,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be,
  output logic            ld_go,
  output logic            byp_go,
  output logic            buf_go
);
  port_src_e sel;

  // fixed priority: loads, then direct writes, then queue retirement
  always_comb begin
    sel = PORT_IDLE;
    if (ld_req)       sel = PORT_LOAD;
    else if (byp_req) sel = PORT_BYPASS;
    else if (buf_req) sel = PORT_RETIRE;

    mem_valid = (sel != PORT_IDLE);
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (sel)
      PORT_LOAD: begin
        mem_addr = ld_addr;
        mem_be   = '1;
      end
      PORT_BYPASS: begin
        mem_we    = 1'b1;
        mem_addr  = byp_addr;
        mem_wdata = byp_data;
        mem_be    = byp_be;
      end
      PORT_RETIRE: begin
        mem_we    = 1'b1;
        mem_addr  = buf_addr;
        mem_wdata = buf_data;
        mem_be    = buf_be;
      end
      default: ;
    endcase
  end

  assign ld_go  = (sel == PORT_LOAD)   && mem_ready;
  assign byp_go = (sel == PORT_BYPASS) && mem_ready;
  assign buf_go = (sel == PORT_RETIRE) && mem_ready;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_go, byp_go, buf_go})); // R6
  AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_go || byp_go || buf_go) |-> (mem_valid && mem_ready)); // R6

endmodule

// File: rtl/ord_store_buf.sv
module ord_store_buf import sbuf_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic            st_bypass,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            ld_valid,
  input  logic            ld_uncached,
  input  logic [AW-1:0]   ld_addr,
  output logic            ld_done,
  output logic [DW-1:0]   ld_rdata,
  input  logic            ev_req,
  output logic            ev_ack,
  output logic            sb_empty,
  output logic            drain_done,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int BEW = DW / 8;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);

  logic [AW-1:0]  ent_addr [DEPTH];
  logic [DW-1:0]  ent_data [DEPTH];
  logic [BEW-1:0] ent_be   [DEPTH];
  logic [PW-1:0]  head_ptr;
  logic [CW-1:0]  occ;

  logic           push, pop, is_full;
  logic           hit, hit_whole;
  logic [DW-1:0]  hit_data;
  logic           ld_wait, ld_fresh;
  logic           fwd_now, part_hold, uc_hold, ld_issue;
  logic           byp_req, st_take;
  logic           ld_go, byp_go;

  sbuf_ring #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .push_be   (st_be),
    .pop       (pop),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_be    (ent_be),
    .head_ptr  (head_ptr),
    .occ       (occ)
  );

  sbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .ent_addr   (ent_addr),
    .ent_data   (ent_data),
    .ent_be     (ent_be),
    .head_ptr   (head_ptr),
    .occ        (occ),
    .probe_addr (ld_addr),
    .hit        (hit),
    .hit_whole  (hit_whole),
    .hit_data   (hit_data)
  );

  // load classification
  assign sb_empty  = (occ == '0);
  assign is_full   = (occ == CW'(DEPTH));
  assign ld_fresh  = ld_valid && !ld_wait;
  assign fwd_now   = ld_fresh && !ld_uncached && hit && hit_whole;
  assign part_hold = ld_fresh && !ld_uncached && hit && !hit_whole;
  assign uc_hold   = ld_fresh && ld_uncached && !sb_empty;
  assign ld_issue  = ld_fresh && !fwd_now && !part_hold && !uc_hold;

  // store intake: an active load is older than any store offered beside it
  assign st_take  = !ld_valid && !ev_req && !is_full;
  assign push     = st_valid && !st_bypass && st_take;
  assign byp_req  = st_valid && st_bypass && !ld_valid && sb_empty;
  assign st_ready = st_bypass ? byp_go : st_take;

  sbuf_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_req    (ld_issue),
    .ld_addr   (ld_addr),
    .byp_req   (byp_req),
    .byp_addr  (st_addr),
    .byp_data  (st_data),
    .byp_be    (st_be),
    .buf_req   (!sb_empty),
    .buf_addr  (ent_addr[head_ptr]),
    .buf_data  (ent_data[head_ptr]),
    .buf_be    (ent_be[head_ptr]),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .ld_go     (ld_go),
    .byp_go    (byp_go),
    .buf_go    (pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ld_wait <= 1'b0;
    else if (ld_go)      ld_wait <= 1'b1;
    else if (mem_rvalid) ld_wait <= 1'b0;
  end

  assign ld_done    = fwd_now || (ld_wait && mem_rvalid);
  assign ld_rdata   = fwd_now ? hit_data : mem_rdata;
  assign ev_ack     = ev_req && sb_empty;
  assign drain_done = pop && (occ == CW'(1)) && !push;

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue |-> !pop); // R6
  AST_FWD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_now |-> !ld_go); // R4
  AST_PARTIAL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    part_hold |-> !ld_go); // R5
  AST_UC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_go && ld_uncached) |-> sb_empty); // R9
  AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_bypass && st_ready) |-> (sb_empty && mem_we)); // R8
  AST_BYPASS_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_bypass && st_ready) |=> sb_empty); // R8
  AST_EVENT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req |=> (occ <= $past(occ))); // R7
  AST_DRAIN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> sb_empty); // R10
  AST_LOAD_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (occ <= $past(occ))); // R11

endmodule

// File: tb/ord_store_buf_test.sv
module ord_store_buf_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 0, st_bypass = 0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_ready;
  logic        ld_valid = 0, ld_uncached = 0;
  logic [31:0] ld_addr = '0;
  logic        ld_done;
  logic [31:0] ld_rdata;
  logic        ev_req = 0;
  logic        ev_ack, sb_empty, drain_done;
  logic        mem_valid, mem_we;
  logic        mem_rdy = 0;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int total = 0;
  int bad = 0;

  // log of every operation the memory port accepted
  logic        lg_we   [64];
  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  int lg_n = 0;
  int dd_cnt = 0;
  int dd_last = -1;

  always #(CLK_P/2) clk = ~clk;

  ord_store_buf uut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_bypass(st_bypass),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_uncached(ld_uncached), .ld_addr(ld_addr),
    .ld_done(ld_done), .ld_rdata(ld_rdata),
    .ev_req(ev_req), .ev_ack(ev_ack), .sb_empty(sb_empty), .drain_done(drain_done),
    .mem_valid(mem_valid), .mem_ready(mem_rdy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_img(logic [31:0] a);
    return a ^ 32'h5A5A_A5A5;
  endfunction

  // memory model: one-cycle read latency, plus an operation log
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_valid && mem_rdy && !mem_we;
      mem_rdata  <= mem_img(mem_addr);
      if (mem_valid && mem_rdy && lg_n < 64) begin
        lg_we[lg_n]   = mem_we;
        lg_addr[lg_n] = mem_addr;
        lg_data[lg_n] = mem_wdata;
        lg_n = lg_n + 1;
      end
      if (drain_done) begin
        dd_cnt  = dd_cnt + 1;
        dd_last = lg_n - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                           input bit byp, input int maxw, output bit acc);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; st_bypass = byp;
    acc = 0;
    for (int n = 0; n < maxw; n++) begin
      #1;
      if (st_ready) begin acc = 1; break; end
      @(negedge clk);
    end
    if (acc) @(negedge clk);
    st_valid = 0; st_bypass = 0;
  endtask

  task automatic ld_start(input logic [31:0] a, input bit uc);
    ld_valid = 1; ld_addr = a; ld_uncached = uc;
  endtask

  task automatic ld_finish(input int maxw, output logic [31:0] d, output bit got);
    got = 0; d = '0;
    for (int n = 0; n < maxw; n++) begin
      #1;
      if (ld_done) begin d = ld_rdata; got = 1; break; end
      @(negedge clk);
    end
    if (got) @(negedge clk);
    ld_valid = 0; ld_uncached = 0;
  endtask

  task automatic wait_empty(input int maxw);
    for (int n = 0; n < maxw; n++) begin
      #1;
      if (sb_empty) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "sb_empty", 32'(sb_empty), 32'd1);
    chk("R1", "mem_valid", 32'(mem_valid), 32'd0);
    chk("R1", "drain_done", 32'(drain_done), 32'd0);
    chk("R1", "ld_done", 32'(ld_done), 32'd0);
    chk("R1", "st_ready", 32'(st_ready), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_fill_and_order;
    int base, dd0;
    bit acc;
    mem_rdy = 0; base = lg_n; dd0 = dd_cnt;
    for (int i = 0; i < 8; i++) begin
      put_store(32'h1000 + 32'(i) * 4, 32'hD000_0000 + 32'(i), 4'hF, 0, 5, acc);
      chk("R3", "store accepted below capacity", 32'(acc), 32'd1);
    end
    put_store(32'h1FF0, 32'hBAD0_BAD0, 4'hF, 0, 3, acc);
    chk("R3", "ninth store refused", 32'(acc), 32'd0);
    chk("R3", "queue not empty", 32'(sb_empty), 32'd0);
    mem_rdy = 1;
    wait_empty(40);
    chk("R2", "write count", 32'(lg_n - base), 32'd8);
    for (int i = 0; i < 8; i++) begin
      chk("R2", "write flag", 32'(lg_we[base + i]), 32'd1);
      chk("R2", "write addr", lg_addr[base + i], 32'h1000 + 32'(i) * 4);
      chk("R2", "write data", lg_data[base + i], 32'hD000_0000 + 32'(i));
    end
    chk("R10", "drain_done pulses", 32'(dd_cnt - dd0), 32'd1);
    chk("R10", "drain_done on last write", 32'(dd_last), 32'(base + 7));
  endtask

  task automatic t_forward_and_partial;
    int base;
    bit acc, got;
    logic [31:0] d;
    mem_rdy = 0; base = lg_n;
    put_store(32'h100, 32'h1111_1111, 4'hF, 0, 5, acc);
    put_store(32'h100, 32'h2222_2222, 4'hF, 0, 5, acc);
    put_store(32'h200, 32'h3333_3333, 4'h3, 0, 5, acc);
    ld_start(32'h100, 0);
    #1;
    chk("R4", "forward same cycle", 32'(ld_done), 32'd1);
    chk("R4", "youngest data", ld_rdata, 32'h2222_2222);
    chk("R4", "no read on port", 32'(mem_we), 32'd1);
    ld_finish(5, d, got);
    // partial lanes: must wait for the entry to retire
    ld_start(32'h200, 0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R5", "partial load held", 32'(ld_done), 32'd0);
      @(negedge clk);
    end
    st_valid = 1; st_addr = 32'h300; st_data = 32'h4444_4444; st_be = 4'hF; st_bypass = 0;
    #1;
    chk("R11", "store blocked behind load", 32'(st_ready), 32'd0);
    st_valid = 0;
    mem_rdy = 1;
    ld_finish(40, d, got);
    chk("R5", "partial load completes", 32'(got), 32'd1);
    chk("R5", "partial load data from memory", d, mem_img(32'h200));
    chk("R5", "ops before read", 32'(lg_n - base), 32'd4);
    chk("R5", "partial entry written before read", {31'd0, lg_we[base + 2]}, 32'd1);
    chk("R5", "read last", {31'd0, lg_we[base + 3]}, 32'd0);
    chk("R11", "blocked store never reached memory", lg_addr[base + 3], 32'h200);
  endtask

  task automatic t_priority;
    int base;
    bit acc, got;
    logic [31:0] d;
    wait_empty(20);
    mem_rdy = 0; base = lg_n;
    put_store(32'h400, 32'hA0A0_0001, 4'hF, 0, 5, acc);
    put_store(32'h404, 32'hA0A0_0002, 4'hF, 0, 5, acc);
    ld_start(32'h500, 0);
    #1;
    chk("R6", "port shows read", 32'(mem_we), 32'd0);
    chk("R6", "read address", mem_addr, 32'h500);
    mem_rdy = 1;
    ld_finish(20, d, got);
    chk("R6", "miss data", d, mem_img(32'h500));
    wait_empty(20);
    chk("R6", "read went first", {31'd0, lg_we[base]}, 32'd0);
    chk("R6", "then oldest write", lg_addr[base + 1], 32'h400);
    chk("R2", "then next write", lg_addr[base + 2], 32'h404);
  endtask

  task automatic t_event;
    int base;
    bit acc, seen;
    mem_rdy = 0; base = lg_n; seen = 0;
    put_store(32'h600, 32'hE000_0006, 4'hF, 0, 5, acc);
    ev_req = 1;
    #1;
    chk("R7", "ev_ack low while queued", 32'(ev_ack), 32'd0);
    st_valid = 1; st_addr = 32'h604; st_data = 32'hE000_0007; st_be = 4'hF;
    #1;
    chk("R7", "store refused during event", 32'(st_ready), 32'd0);
    st_valid = 0;
    mem_rdy = 1;
    @(negedge clk);
    for (int n = 0; n < 20; n++) begin
      #1;
      if (ev_ack) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R7", "ev_ack rises", 32'(seen), 32'd1);
    chk("R7", "empty at ack", 32'(sb_empty), 32'd1);
    chk("R7", "only the older store written", 32'(lg_n - base), 32'd1);
    ev_req = 0;
    @(negedge clk);
  endtask

  task automatic t_bypass;
    int base;
    bit acc;
    mem_rdy = 0; base = lg_n;
    put_store(32'h700, 32'hB000_0700, 4'hF, 0, 5, acc);
    st_valid = 1; st_bypass = 1; st_addr = 32'h704; st_data = 32'hB000_0704; st_be = 4'hF;
    #1;
    chk("R8", "bypass held while queued", 32'(st_ready), 32'd0);
    chk("R8", "queued write on port first", mem_addr, 32'h700);
    mem_rdy = 1;
    put_store(32'h704, 32'hB000_0704, 4'hF, 1, 20, acc);
    chk("R8", "bypass accepted", 32'(acc), 32'd1);
    #1;
    chk("R8", "bypass never queued", 32'(sb_empty), 32'd1);
    chk("R8", "direct write after drain", lg_addr[base + 1], 32'h704);
    chk("R8", "direct write data", lg_data[base + 1], 32'hB000_0704);
    @(negedge clk);
  endtask

  task automatic t_uncached;
    int base;
    bit acc, got;
    logic [31:0] d;
    mem_rdy = 0; base = lg_n;
    put_store(32'h800, 32'hC000_0800, 4'hF, 0, 5, acc);
    ld_start(32'h800, 1);
    #1;
    chk("R9", "no forward for uncached", 32'(ld_done), 32'd0);
    chk("R9", "port holds write", 32'(mem_we), 32'd1);
    mem_rdy = 1;
    ld_finish(20, d, got);
    chk("R9", "uncached data from memory", d, mem_img(32'h800));
    chk("R9", "write before uncached read", {31'd0, lg_we[base]}, 32'd1);
    chk("R9", "read after drain", {31'd0, lg_we[base + 1]}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_and_order();
    t_forward_and_partial();
    t_priority();
    t_event();
    t_bypass();
    t_uncached();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule